// File: doc/BRIEF.md
# Cache Read-Miss Watchdog

This block watches a data-cache miss controller while it waits for the refill of a read miss. If the memory response never arrives, the controller would otherwise hang forever. When the controller issues a read miss, the block arms itself, clears a wait counter and latches the virtual address of the access. Each cycle the controller spends in its wait state advances the counter. The exception is a cycle in which a coherence request takes the controller away to service it; that cycle is not counted.

If the registered count equals the programmed threshold on a counted wait cycle, the miss is abandoned. On the next cycle the block returns a processor data response with valid and error both set. It loads an error-type register with the read-timeout code and copies the latched address into a bad-address register. The one-cycle response pulse also tells the controller to return to idle.

A refill that completes first disarms the block quietly. After reset the threshold is all ones, which in practice disables the watchdog until software programs a smaller value.

Top module: `rdmiss_watchdog`

## Requirements
- R1: After reset the threshold is all ones (2^32-1), and `rsp_valid`, `rsp_error`, `err_code` and `bad_vaddr` are zero. With that default threshold, 300 wait cycles raise no response.
- R2: A `miss_issue` pulse arms the block, clears the wait counter to zero and latches `miss_vaddr`. This also applies while a miss is already armed, which restarts the timing.
- R3: The counter advances by one only on a cycle with the block armed, `miss_wait` high, `coh_pending` low, `refill_done` low and no `miss_issue`. Cycles with `miss_wait` low are not counted.
- R4: A timeout is detected on a counted cycle whose registered count equals the threshold (equality, not greater-than). With threshold T, it falls on the (T+1)-th counted wait cycle; T=0 times out on the first counted cycle.
- R5: A timeout drives `rsp_valid` and `rsp_error` both high for exactly one cycle, starting the cycle after the counted cycle that timed out.
- R6: On a timeout, `err_code` (16 bits) is loaded with 0x1200. It holds that value until the next timeout or reset.
- R7: On a timeout, `bad_vaddr` is loaded with the address latched at the most recent `miss_issue`.
- R8: A timeout disarms the block. Further wait cycles produce no response until a new `miss_issue`.
- R9: A wait cycle with `coh_pending` high neither advances the counter nor can time out.
- R10: `refill_done` while armed disarms the block without any response. This holds even in a cycle where the count equals the threshold, because the refill has priority.
- R11: A threshold write (`thr_we`) takes effect only when no miss is armed. A write while armed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_issue | input | 1 | Controller issues a data read miss this cycle |
| miss_vaddr | input | 32 | Virtual address of the missing access, sampled with `miss_issue` |
| miss_wait | input | 1 | Controller is in its refill-wait state this cycle |
| coh_pending | input | 1 | Coherence request preempts the wait this cycle |
| refill_done | input | 1 | Refill response for the pending miss has completed |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 32 | New threshold value |
| rsp_valid | output | 1 | Processor data response valid (timeout abort pulse) |
| rsp_error | output | 1 | Processor data response carries an error |
| err_code | output | 16 | Error-type register |
| bad_vaddr | output | 32 | Bad-address register |

## Verification
The bench aims at the off-by-one edges of the equality compare. It uses a threshold of zero and a small threshold where the pulse must land on exactly the (T+1)-th counted cycle. A design using greater-than or comparing the next count would shift that pulse by one cycle. Coherence cycles interleaved with wait cycles check that a preempted cycle is neither counted nor able to fire. Idle cycles inside the wait check that only real wait cycles count.

A refill landing in the very cycle the count meets the threshold must win; a wrong priority produces a spurious error. A threshold write while a miss is armed must be ignored, or a zero written mid-miss would fire at once. A re-issued miss must restart the count and report the new address, not the old one.

// File: rtl/rmw_pkg.sv
// Package: shared constants for the read-miss watchdog.
// Assumes a 16-bit error-type register whose read-timeout code is fixed.
package rmw_pkg;
    localparam int          RMW_CNT_W        = 32;
    localparam int          RMW_ADDR_W       = 32;
    localparam int          RMW_ERR_W        = 16;
    localparam logic [15:0] RMW_READ_TIMEOUT = 16'h1200;
endpackage

// File: rtl/rmw_threshold_reg.sv
// Threshold register. Resets to all ones (watchdog effectively off).
// Accepts a write only while no miss is armed, so a pending miss is
// always judged against the limit it started with.
module rmw_threshold_reg #(
    parameter int CNT_W = rmw_pkg::RMW_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             armed,
    output logic [CNT_W-1:0] limit
);
    // Load the limit on an accepted write; all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= '1;
        else if (wr_en && !armed)
            limit <= wr_data;
    end
endmodule

// File: rtl/rmw_wait_counter.sv
// Wait counter. Cleared when a miss is issued, advanced by one on each
// counted wait cycle; wraps naturally at its width.
module rmw_wait_counter #(
    parameter int CNT_W = rmw_pkg::RMW_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Clear has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (advance)
            count <= count + ONE;
    end
endmodule

// File: rtl/rmw_fault_capture.sv
// Fault capture. Latches the miss address at issue, and on a timeout
// loads the error-type and bad-address registers and pulses the
// processor response with valid and error for one cycle.
module rmw_fault_capture #(
    parameter int                 ADDR_W       = rmw_pkg::RMW_ADDR_W,
    parameter int                 ERR_W        = rmw_pkg::RMW_ERR_W,
    parameter logic [ERR_W-1:0]   TIMEOUT_CODE = ERR_W'(rmw_pkg::RMW_READ_TIMEOUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_vaddr,
    input  logic              fire,
    output logic [ADDR_W-1:0] saved_vaddr,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [ERR_W-1:0]  err_code,
    output logic [ADDR_W-1:0] bad_vaddr
);
    // Hold the virtual address of the most recently issued miss.
    always_ff @(posedge clk) begin
        if (!rst_n)
            saved_vaddr <= '0;
        else if (issue)
            saved_vaddr <= issue_vaddr;
    end

    // One-cycle error response following a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
        end else begin
            rsp_valid <= fire;
            rsp_error <= fire;
        end
    end

    // Error-type and bad-address registers, loaded only on a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_code  <= '0;
            bad_vaddr <= '0;
        end else if (fire) begin
            err_code  <= TIMEOUT_CODE;
            bad_vaddr <= saved_vaddr;
        end
    end
endmodule

// File: rtl/rdmiss_watchdog.sv
// Read-miss watchdog top. Arms on a read miss, counts wait cycles that
// are not preempted by coherence, and aborts the miss with an error
// response when the registered count equals the threshold.
// Assumes the controller holds miss_wait while waiting and that a
// rsp_valid pulse sends it back to idle.
module rdmiss_watchdog #(
    parameter int               CNT_W        = rmw_pkg::RMW_CNT_W,
    parameter int               ADDR_W       = rmw_pkg::RMW_ADDR_W,
    parameter int               ERR_W        = rmw_pkg::RMW_ERR_W,
    parameter logic [ERR_W-1:0] TIMEOUT_CODE = ERR_W'(rmw_pkg::RMW_READ_TIMEOUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_issue,
    input  logic [ADDR_W-1:0] miss_vaddr,
    input  logic              miss_wait,
    input  logic              coh_pending,
    input  logic              refill_done,
    input  logic              thr_we,
    input  logic [CNT_W-1:0]  thr_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [ERR_W-1:0]  err_code,
    output logic [ADDR_W-1:0] bad_vaddr
);
    logic              pending_q;
    logic              count_step;
    logic              timeout_hit;
    logic [CNT_W-1:0]  wait_count;
    logic [CNT_W-1:0]  thr_value;
    logic [ADDR_W-1:0] saved_vaddr_q;

    // A cycle counts only when armed, really waiting and not preempted.
    always_comb begin
        count_step  = pending_q && miss_wait && !coh_pending
                      && !refill_done && !miss_issue;
        timeout_hit = count_step && (wait_count == thr_value);
    end

    // Armed flag: set by a new miss, dropped by refill or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (miss_issue)
            pending_q <= 1'b1;
        else if (refill_done || timeout_hit)
            pending_q <= 1'b0;
    end

    rmw_threshold_reg #(.CNT_W(CNT_W)) thr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (thr_we),
        .wr_data (thr_wdata),
        .armed   (pending_q),
        .limit   (thr_value)
    );

    rmw_wait_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (miss_issue),
        .advance (count_step),
        .count   (wait_count)
    );

    rmw_fault_capture #(
        .ADDR_W       (ADDR_W),
        .ERR_W        (ERR_W),
        .TIMEOUT_CODE (TIMEOUT_CODE)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (miss_issue),
        .issue_vaddr (miss_vaddr),
        .fire        (timeout_hit),
        .saved_vaddr (saved_vaddr_q),
        .rsp_valid   (rsp_valid),
        .rsp_error   (rsp_error),
        .err_code    (err_code),
        .bad_vaddr   (bad_vaddr)
    );
endmodule

// File: rtl/rdmiss_watchdog_chk.sv
// Checker for the read-miss watchdog, bound into the top module.
// Relates the response outputs to the internal armed, counter and
// threshold state across cycles.
module rdmiss_watchdog_chk #(
    parameter int               CNT_W        = 32,
    parameter int               ADDR_W       = 32,
    parameter int               ERR_W        = 16,
    parameter logic [ERR_W-1:0] TIMEOUT_CODE = 16'h1200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_issue,
    input logic              coh_pending,
    input logic              thr_we,
    input logic              rsp_valid,
    input logic              rsp_error,
    input logic [ERR_W-1:0]  err_code,
    input logic [ADDR_W-1:0] bad_vaddr,
    input logic              pending,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  threshold,
    input logic [ADDR_W-1:0] saved_vaddr
);
    // R1: threshold comes out of reset at all ones
    a_r1_thr_reset: assert property (@(posedge clk)
        !rst_n |=> threshold == '1);

    // R2: issuing a miss clears the count
    a_r2_issue_clears: assert property (@(posedge clk) disable iff (!rst_n)
        miss_issue |=> count == '0);

    // R5: response pulse lasts one cycle and always carries error
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r5_error_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == rsp_error);

    // R6: a response reports the read-timeout code
    a_r6_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> err_code == TIMEOUT_CODE);

    // R7: the bad address is the latched miss address
    a_r7_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> bad_vaddr == saved_vaddr);

    // R8: after a timeout the miss is abandoned
    a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !pending);

    // R9: a preempted cycle leaves the count alone
    a_r9_coh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pending && coh_pending && !miss_issue |=> $stable(count));

    // R11: a write during an armed miss does not change the threshold
    a_r11_thr_locked: assert property (@(posedge clk) disable iff (!rst_n)
        pending && thr_we |=> $stable(threshold));
endmodule

bind rdmiss_watchdog rdmiss_watchdog_chk #(
    .CNT_W        (CNT_W),
    .ADDR_W       (ADDR_W),
    .ERR_W        (ERR_W),
    .TIMEOUT_CODE (TIMEOUT_CODE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_issue  (miss_issue),
    .coh_pending (coh_pending),
    .thr_we      (thr_we),
    .rsp_valid   (rsp_valid),
    .rsp_error   (rsp_error),
    .err_code    (err_code),
    .bad_vaddr   (bad_vaddr),
    .pending     (pending_q),
    .count       (wait_count),
    .threshold   (thr_value),
    .saved_vaddr (saved_vaddr_q)
);

// File: tb/rdmiss_watchdog_tb_top.sv
`timescale 1ns/1ps
// Bench for the read-miss watchdog: a behavioural reference model is
// compared on every clock, plus directed scenario checks.
module rdmiss_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_issue = 1'b0;
    logic [31:0] miss_vaddr = '0;
    logic        miss_wait = 1'b0;
    logic        coh_pending = 1'b0;
    logic        refill_done = 1'b0;
    logic        thr_we = 1'b0;
    logic [31:0] thr_wdata = '0;
    logic        rsp_valid, rsp_error;
    logic [15:0] err_code;
    logic [31:0] bad_vaddr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rdmiss_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .miss_issue(miss_issue), .miss_vaddr(miss_vaddr),
        .miss_wait(miss_wait), .coh_pending(coh_pending), .refill_done(refill_done),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .rsp_valid(rsp_valid),
        .rsp_error(rsp_error), .err_code(err_code), .bad_vaddr(bad_vaddr)
    );

    // Reference model state
    bit          m_armed;
    bit [31:0]   m_waits;
    bit [31:0]   m_limit;
    bit [31:0]   m_addr;
    bit          m_rsp;
    bit [15:0]   m_code;
    bit [31:0]   m_bad;

    always @(posedge clk) begin
        bit was_armed;
        cycles++;
        if (!rst_n) begin
            m_armed = 0; m_waits = 0; m_limit = 32'hFFFF_FFFF; m_addr = 0;
            m_rsp = 0; m_code = 0; m_bad = 0;
        end else begin
            was_armed = m_armed;
            m_rsp = 0;
            if (miss_issue) begin
                m_armed = 1; m_waits = 0; m_addr = miss_vaddr;
            end else if (m_armed && refill_done) begin
                m_armed = 0;
            end else if (m_armed && miss_wait && !coh_pending) begin
                if (m_waits == m_limit) begin
                    m_rsp = 1; m_code = 16'h1200; m_bad = m_addr; m_armed = 0;
                end
                m_waits = m_waits + 1;
            end
            if (thr_we && !was_armed) m_limit = thr_wdata;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R5 R6 R7)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 model rsp_valid", rsp_valid, m_rsp);
            check("R5 model rsp_error", rsp_error, m_rsp);
            check("R6 model err_code", err_code, m_code);
            check("R7 model bad_vaddr", bad_vaddr, m_bad);
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_thr(input logic [31:0] v);
        thr_we = 1; thr_wdata = v; step(); thr_we = 0;
    endtask

    task automatic issue(input logic [31:0] a);
        miss_issue = 1; miss_vaddr = a; step(); miss_issue = 0;
    endtask

    task automatic refill();
        refill_done = 1; step(); refill_done = 0;
    endtask

    // n wait cycles; optional coherence on odd cycles. Returns first pulse index and pulse count.
    task automatic do_wait(input int n, input bit coh_alt, output int hit, output int pulses);
        hit = -1; pulses = 0;
        for (int k = 0; k < n; k++) begin
            miss_wait = 1;
            coh_pending = coh_alt && (k % 2 == 1);
            step();
            if (rsp_valid) begin
                pulses++;
                if (hit < 0) hit = k;
            end
        end
        miss_wait = 0; coh_pending = 0;
    endtask

    initial begin
        int hit, pulses;
        repeat (3) step();
        rst_n = 1;
        check("R1 reset rsp_valid", rsp_valid, 0);
        check("R1 reset err_code", err_code, 0);
        check("R1 reset bad_vaddr", bad_vaddr, 0);

        // R1: default threshold never fires in a short wait
        issue(32'hA000_0010);
        do_wait(300, 0, hit, pulses);
        check("R1 default threshold no timeout", hit, -1);
        refill();

        // R4 R6 R7 R8: threshold 5 fires on sixth wait cycle, once
        set_thr(5);
        issue(32'hA000_0020);
        do_wait(10, 0, hit, pulses);
        check("R4 timeout index thr=5", hit, 5);
        check("R8 single pulse", pulses, 1);
        check("R6 err_code 0x1200", err_code, 16'h1200);
        check("R7 bad_vaddr captured", bad_vaddr, 32'hA000_0020);

        // R4 boundary: threshold 0 fires on first wait cycle
        set_thr(0);
        issue(32'hA000_0030);
        do_wait(4, 0, hit, pulses);
        check("R4 timeout index thr=0", hit, 0);

        // R9: coherence on odd cycles delays timeout
        set_thr(3);
        issue(32'hA000_0040);
        do_wait(12, 1, hit, pulses);
        check("R9 coherence cycles not counted", hit, 6);

        // R3: idle cycles inside the wait do not count
        issue(32'hA000_0050);
        do_wait(2, 0, hit, pulses);
        check("R3 no early pulse", hit, -1);
        repeat (5) step();
        do_wait(5, 0, hit, pulses);
        check("R3 idle cycles ignored", hit, 1);

        // R10: refill before threshold, then more waits raise nothing
        set_thr(4);
        issue(32'hA000_0060);
        do_wait(3, 0, hit, pulses);
        refill();
        do_wait(10, 0, hit, pulses);
        check("R10 refill disarms", hit, -1);
        check("R10 err regs untouched", bad_vaddr, 32'hA000_0050);

        // R10: refill in the same cycle as the equality wins
        set_thr(2);
        issue(32'hA000_0070);
        do_wait(2, 0, hit, pulses);
        miss_wait = 1; refill_done = 1; step(); miss_wait = 0; refill_done = 0;
        check("R10 refill beats timeout", rsp_valid, 0);
        do_wait(4, 0, hit, pulses);
        check("R10 no late timeout", hit, -1);

        // R11: write while armed ignored, later write accepted
        set_thr(10);
        issue(32'hA000_0080);
        set_thr(0);
        do_wait(5, 0, hit, pulses);
        check("R11 armed write ignored", hit, -1);
        refill();
        set_thr(1);
        issue(32'hA000_0090);
        do_wait(4, 0, hit, pulses);
        check("R11 idle write applied", hit, 1);

        // R2: re-issue restarts the count and replaces the address
        set_thr(4);
        issue(32'hA000_00A0);
        do_wait(3, 0, hit, pulses);
        issue(32'hB000_00B0);
        do_wait(10, 0, hit, pulses);
        check("R2 restart count", hit, 4);
        check("R2 new address reported", bad_vaddr, 32'hB000_00B0);

        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule